// File: doc/BRIEF.md
# Periodic DRAM Refresh Request Timer

This block paces DRAM refresh. A binary counter advances on every clock and never stops. Each time it wraps, the block raises a refresh request toward the memory sequencer. The request is a level, not a pulse. It stays high until the sequencer answers with an acknowledge. The sequencer raises that acknowledge only once the DRAM is idle, and it keeps it high until it sees the request fall.

Missed periods are not counted. If the sequencer leaves a request unanswered past the next wrap, the wrap only sets a flag that is already set. At most one refresh is therefore ever outstanding. A request can wait up to one full period before a later one takes its place. The block does not perform the refresh itself.

Top module: `refresh_timer`

## Requirements
- R1: While `rst_n` is low, `rfsh_req` is 0 and the period counter is held at zero. After reset is released, the first request therefore again appears a full period later.
- R2: After reset is released, `rfsh_req` first goes high exactly 2^CNT_W clock edges later. With the default CNT_W = 7, this is 128 edges.
- R3: The counter runs freely and ignores the acknowledge. Successive rising edges of `rfsh_req` are exactly 2^CNT_W clocks apart, however long each request waited to be serviced.
- R4: Once set, `rfsh_req` stays at 1 on every clock edge at which `rfsh_ack` is 0.
- R5: An edge that samples `rfsh_ack` = 1 while `rfsh_req` = 1 drives `rfsh_req` to 0 from that edge on, unless that same edge is a counter wrap.
- R6: On a counter wrap (the counter held all ones before the edge), `rfsh_req` is 1 after the edge even if `rfsh_ack` is 1 in that cycle. Setting the request wins over clearing it.
- R7: A request left unserviced across one or more further wraps stays a single level. One acknowledge clears it, and no further request appears before the next regular wrap.
- R8: `rfsh_ack` sampled while `rfsh_req` is 0 has no effect. The request stays 0 and the timing of the next request is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rfsh_ack | input | 1 | Refresh access in progress, from the memory sequencer |
| rfsh_req | output | 1 | Sticky refresh request |

## Verification
Two events can land in the same cycle: the counter wrap that sets the request, and a sequencer acknowledge that clears it. The bench leaves a request pending until the counter stands at all ones. It then raises the acknowledge so that the acknowledge is sampled on the wrap edge, and expects the request to be high after that edge rather than cleared. It then drops the acknowledge, confirms the request is still held, and clears it with a second acknowledge to show that the level set on the wrap edge was a fresh one.

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_ack,
  output logic rfsh_req
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rfsh_req <= 1'b0;
    else        rfsh_req <= wrap | (rfsh_req & ~rfsh_ack);
  end

endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             req,
  input logic [CNT_W-1:0] cnt
);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && ack && (cnt != '1) |=> !req);

  // R6
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> req);

  // R8
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req && (cnt != '1) |=> !req);

  // R1
  always @(posedge clk)
    if (!rst_n) reset_chk: assert (!req && cnt == '0);

endmodule

bind refresh_timer refresh_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(rfsh_ack), .req(rfsh_req), .cnt(cnt)
);

// File: tb/test_refresh_timer.sv
module test_refresh_timer;
  localparam int CNT_W = 7;
  localparam int PER   = 1 << CNT_W;
  localparam int NV    = 6;
  localparam int ACK_DLY [NV] = '{0, 1, 5, 50, 100, 126};
  localparam int EXP_GAP [NV] = '{PER, PER, PER, PER, PER, PER};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfsh_ack = 1'b0;
  logic rfsh_req;
  int checks = 0;
  int errors = 0;
  int ph = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  refresh_timer #(.CNT_W(CNT_W)) i_refresh_timer (
    .clk(clk), .rst_n(rst_n), .rfsh_ack(rfsh_ack), .rfsh_req(rfsh_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    ph = (ph + 1) % PER;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic count_to_rise(output int n);
    n = 0;
    do begin step(); n++; end while (!rfsh_req && n < 3 * PER);
  endtask

  task automatic wait_ph(input int target);
    while (ph != target) step();
  endtask

  initial begin
    int n;
    int bad;
    repeat (3) @(posedge clk);
    #1;
    chk(rfsh_req == 1'b0, "R1", rfsh_req, 0);
    rst_n = 1'b1;
    ph = 0;
    count_to_rise(n);
    chk(n == PER, "R2", n, PER);

    for (int v = 0; v < NV; v++) begin
      bad = 0;
      for (int i = 0; i < ACK_DLY[v]; i++) begin
        step();
        if (!rfsh_req) bad++;
      end
      chk(bad == 0, "R4", bad, 0);
      rfsh_ack = 1'b1;
      step();
      chk(rfsh_req == 1'b0, "R5", rfsh_req, 0);
      rfsh_ack = 1'b0;
      count_to_rise(n);
      n = n + ACK_DLY[v] + 1;
      chk(n == EXP_GAP[v], "R3", n, EXP_GAP[v]);
    end

    // R6: acknowledge sampled on the wrap edge
    wait_ph(PER - 1);
    chk(rfsh_req == 1'b1, "R4", rfsh_req, 1);
    rfsh_ack = 1'b1;
    step();
    chk(rfsh_req == 1'b1, "R6", rfsh_req, 1);
    rfsh_ack = 1'b0;
    step();
    chk(rfsh_req == 1'b1, "R6", rfsh_req, 1);
    rfsh_ack = 1'b1;
    step();
    chk(rfsh_req == 1'b0, "R5", rfsh_req, 0);
    rfsh_ack = 1'b0;

    // R7: request left pending across a further wrap
    wait_ph(0);
    repeat (PER + 10) step();
    chk(rfsh_req == 1'b1, "R7", rfsh_req, 1);
    rfsh_ack = 1'b1;
    step();
    chk(rfsh_req == 1'b0, "R7", rfsh_req, 0);
    rfsh_ack = 1'b0;
    bad = 0;
    while (ph != 0) begin
      step();
      if (ph != 0 && rfsh_req) bad++;
    end
    chk(bad == 0, "R7", bad, 0);
    chk(rfsh_req == 1'b1, "R3", rfsh_req, 1);

    // R8: acknowledge while no request is pending
    rfsh_ack = 1'b1;
    step();
    bad = 0;
    repeat (40) begin
      step();
      if (rfsh_req) bad++;
    end
    rfsh_ack = 1'b0;
    chk(bad == 0, "R8", bad, 0);
    wait_ph(PER - 1);
    chk(rfsh_req == 1'b0, "R8", rfsh_req, 0);
    step();
    chk(rfsh_req == 1'b1, "R8", rfsh_req, 1);

    // R1: reset in the middle of a pending request
    repeat (5) step();
    rst_n = 1'b0;
    #1;
    chk(rfsh_req == 1'b0, "R1", rfsh_req, 0);
    step();
    rst_n = 1'b1;
    ph = 0;
    count_to_rise(n);
    chk(n == PER, "R1", n, PER);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule